// File: doc/BRIEF.md
# Delta-Sigma ADC Command Sequencer

This block is an SPI master that runs whole command scripts against a serial delta-sigma converter for a host. The host gives one start request together with an operation select. The block then holds chip-select low for the full script. It clocks out the command bytes, inserts the fixed settling pauses and waits for the converter's data-ready line. It shifts the returned bytes in MSB first. When it finishes it returns a one-cycle done pulse along with the captured data.

Two scripts are built in. The register dump first stops continuous data output. It then asks for twelve registers starting at address 0 and clocks filler bytes to read them back. The conversion read sends the synchronise and wake commands, waits for data-ready, issues the read-data command and collects a 24-bit two's-complement sample. The serial clock comes from a divider on the system clock. A parameter selects the edge on which data is launched and the edge on which it is captured. Every pause is a parameter counted in system-clock cycles, and each default is derived from the clock frequency.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Out of reset, cs_n_o is high, sclk_o is low, busy_o and done_o are low, and reg_data_o and conv_data_o read zero.
- R2: sclk_o idles low whenever cs_n_o is high. While a byte moves, each SCLK level lasts exactly HALF system-clock cycles, with HALF = CLK_HZ / (2*SCLK_HZ), which is 36 at 125 MHz.
- R3: With SAMPLE_ON_FALL=1, din_o changes on SCLK rising edges and dout_i is captured on falling edges. With SAMPLE_ON_FALL=0 the two edges swap. Bytes move MSB first in both modes.
- R4: A register dump sends 0x0F, 0x10, then NREG-1 (0x0B by default), then NREG filler bytes of 0xFF, all inside one chip-select low window. The byte returned during filler i lands in reg_data_o[8i+7:8i].
- R5: A conversion read sends 0xFC, 0xFF, 0x01, then three 0xFF fillers in one chip-select window. The three returned bytes, MSB first, form conv_data_o as a signed 24-bit value.
- R6: At least WAIT_CYC system-clock cycles (at least 6 µs, 750 at 125 MHz) pass between the end of 0xFC and the start of 0xFF, between 0xFF and 0x01, and between 0x01 and the first data filler.
- R7: drdy_n_i passes through two flip-flops. The 0x01 command starts only after the synchronised data-ready line has been seen low.
- R8: If data-ready stays high for DRDY_TO_CYC cycles, the block raises chip-select without sending 0x01 and ends with err_o high and a done pulse. A later successful operation clears err_o.
- R9: A start request that arrives while busy_o is high is ignored. The running script continues unchanged and no extra done pulse follows.
- R10: After chip-select rises, busy_o stays high for at least CSH_CYC = 2*HALF cycles. done_o is a one-cycle pulse in the cycle busy_o falls, and err_o is valid with it.
- R11: op_i = 0 selects the register dump and op_i = 1 selects the conversion read. The value is taken in the cycle start_i is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| op_i | input | 1 | Operation: 0 register dump, 1 conversion read |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Data-ready timeout on the last operation |
| reg_data_o | output | NREG*8 | Register bytes, address i at bits [8i+7:8i] |
| conv_data_o | output | 24 | Signed conversion result |
| cs_n_o | output | 1 | Converter chip-select, active low |
| sclk_o | output | 1 | Serial clock |
| din_o | output | 1 | Serial data to the converter |
| dout_i | input | 1 | Serial data from the converter |
| drdy_n_i | input | 1 | Converter data-ready, active low, asynchronous |

## Verification
All results are due in the cycle done_o pulses. That is at least CSH_CYC cycles after chip-select rises, and the length of a script depends on its byte count, the pauses and how long data-ready takes. The checks therefore do not count cycles from start. A monitor samples on the falling clock edge, waits for done_o and compares the captured bytes, the error flag and the command stream a converter model saw against an item the driver queued. Timing rules are checked in absolute time, which is exact for the SCLK half period and a lower bound for the pauses, the data-ready gate and the chip-select high time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam logic [7:0] CMD_STOPC  = 8'h0F;
  localparam logic [7:0] CMD_RDREG  = 8'h10;
  localparam logic [7:0] CMD_SYNC   = 8'hFC;
  localparam logic [7:0] CMD_WAKE   = 8'hFF;
  localparam logic [7:0] CMD_RDDATA = 8'h01;
  localparam logic [7:0] FILLER     = 8'hFF;

  typedef enum logic [1:0] {K_BYTE, K_WAIT, K_DRDY, K_END} step_kind_t;
  typedef enum logic [1:0] {C_NONE, C_REG, C_CONV} cap_t;

  typedef struct packed {
    step_kind_t  kind;
    logic [7:0]  data;
    cap_t        cap;
    logic [4:0]  slot;
  } step_t;

  // serial clock half period in system cycles, at least 1
  function automatic int calc_half(input longint clk_hz, input longint sclk_hz);
    longint h;
    h = clk_hz / (2 * sclk_hz);
    return (h < 1) ? 1 : int'(h);
  endfunction

  // cycles covering a time in microseconds, rounded up
  function automatic int calc_wait(input longint clk_hz, input int us);
    return int'((clk_hz * longint'(us) + 64'd999_999) / 64'd1_000_000);
  endfunction

  function automatic step_t dump_step(input logic [4:0] idx, input int nreg);
    step_t s;
    s = '{kind: K_END, data: 8'h00, cap: C_NONE, slot: 5'd0};
    if (idx == 5'd0) begin
      s.kind = K_BYTE; s.data = CMD_STOPC;
    end else if (idx == 5'd1) begin
      s.kind = K_BYTE; s.data = CMD_RDREG;
    end else if (idx == 5'd2) begin
      s.kind = K_BYTE; s.data = 8'(nreg - 1);
    end else if (int'(idx) < 3 + nreg) begin
      s.kind = K_BYTE; s.data = FILLER; s.cap = C_REG; s.slot = idx - 5'd3;
    end
    return s;
  endfunction

  function automatic step_t conv_step(input logic [4:0] idx);
    step_t s;
    s = '{kind: K_END, data: 8'h00, cap: C_NONE, slot: 5'd0};
    case (idx)
      5'd0: begin s.kind = K_BYTE; s.data = CMD_SYNC; end
      5'd1: s.kind = K_WAIT;
      5'd2: begin s.kind = K_BYTE; s.data = CMD_WAKE; end
      5'd3: s.kind = K_WAIT;
      5'd4: s.kind = K_DRDY;
      5'd5: begin s.kind = K_BYTE; s.data = CMD_RDDATA; end
      5'd6: s.kind = K_WAIT;
      5'd7, 5'd8, 5'd9: begin s.kind = K_BYTE; s.data = FILLER; s.cap = C_CONV; end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/drdy_sync2.sv
module drdy_sync2 #(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_byte_io.sv
module spi_byte_io #(
  parameter int HALF           = 36,
  parameter bit SAMPLE_ON_FALL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int HW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [HW-1:0] hcnt;
  logic [3:0]    ph;
  logic          act, sclk_q, mosi_q, done_q;
  logic [7:0]    tx_sh, rx_sh;

  // named events for the checks
  wire half_end   = act && (hcnt == HW'(HALF - 1));
  wire rise_ev    = half_end && !ph[0];
  wire fall_ev    = half_end &&  ph[0];
  wire launch_ev  = SAMPLE_ON_FALL ? rise_ev : fall_ev;
  wire capture_ev = SAMPLE_ON_FALL ? fall_ev : rise_ev;
  wire last_ev    = half_end && (ph == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt   <= '0;
      ph     <= '0;
      act    <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !act) begin
        act    <= 1'b1;
        hcnt   <= '0;
        ph     <= '0;
        sclk_q <= 1'b0;
        mosi_q <= tx_i[7];
        tx_sh  <= SAMPLE_ON_FALL ? tx_i : {tx_i[6:0], 1'b0};
      end else if (act) begin
        if (half_end) begin
          hcnt   <= '0;
          ph     <= ph + 4'd1;
          sclk_q <= ~sclk_q;
        end else begin
          hcnt <= hcnt + HW'(1);
        end
        if (launch_ev) begin
          mosi_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
        if (capture_ev) rx_sh <= {rx_sh[6:0], miso_i};
        if (last_ev) begin
          act    <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign busy_o = act;
  assign done_o = done_q;
  assign rx_o   = rx_sh;

  // R2: SCLK moves only at the end of a counted half period
  p_sclk_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_q) |-> $past(half_end));
  // R3: data moves only on the launch edge once a byte runs
  p_mosi_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(act) && !$past(go_i) && !$stable(mosi_q)) |-> $past(launch_ev));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter longint CLK_HZ         = 125_000_000,
  parameter longint SCLK_HZ        = 1_714_000,
  parameter int     SETTLE_US      = 6,
  parameter int     NREG           = 12,
  parameter bit     SAMPLE_ON_FALL = 1'b1,
  parameter int     DRDY_TO_CYC    = 2_000_000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   op_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [NREG*8-1:0]      reg_data_o,
  output logic signed [23:0]     conv_data_o,
  output logic                   cs_n_o,
  output logic                   sclk_o,
  output logic                   din_o,
  input  logic                   dout_i,
  input  logic                   drdy_n_i
);
  localparam int HALF     = calc_half(CLK_HZ, SCLK_HZ);
  localparam int WAIT_CYC = calc_wait(CLK_HZ, SETTLE_US);
  localparam int CSH_CYC  = 2 * HALF;
  localparam int MAX_A    = (WAIT_CYC > CSH_CYC) ? WAIT_CYC : CSH_CYC;
  localparam int CNT_MAX  = (DRDY_TO_CYC > MAX_A) ? DRDY_TO_CYC : MAX_A;
  localparam int CW       = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_BYTE, S_WAIT, S_DRDY, S_CSH} state_t;

  state_t             state;
  logic               op_q, cs_n_q, err_q, err_out, done_q;
  logic [4:0]         idx;
  logic [CW-1:0]      cnt;
  logic [NREG*8-1:0]  reg_q;
  logic [23:0]        conv_q;
  logic               drdy_s_n;
  logic               eng_busy, eng_done;
  logic [7:0]         eng_rx;
  step_t              cur;

  drdy_sync2 #(.RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(drdy_n_i), .q_o(drdy_s_n)
  );

  always_comb cur = op_q ? conv_step(idx) : dump_step(idx, NREG);

  // named events for the checks
  wire eng_go      = (state == S_RUN) && (cur.kind == K_BYTE);
  wire rdata_go    = eng_go && op_q && (cur.data == CMD_RDDATA);
  wire drdy_low    = !drdy_s_n;
  wire to_expire   = (state == S_DRDY) && drdy_s_n && (cnt == '0);
  wire seq_done_ev = (state == S_CSH) && (cnt == '0);
  wire accept      = (state == S_IDLE) && start_i;

  spi_byte_io #(.HALF(HALF), .SAMPLE_ON_FALL(SAMPLE_ON_FALL)) u_io (
    .clk(clk), .rst_n(rst_n), .go_i(eng_go), .tx_i(cur.data), .miso_i(dout_i),
    .sclk_o(sclk_o), .mosi_o(din_o), .busy_o(eng_busy), .done_o(eng_done), .rx_o(eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= 1'b0;
      cs_n_q  <= 1'b1;
      err_q   <= 1'b0;
      err_out <= 1'b0;
      done_q  <= 1'b0;
      idx     <= '0;
      cnt     <= '0;
      reg_q   <= '0;
      conv_q  <= '0;
    end else begin
      done_q <= seq_done_ev;
      case (state)
        S_IDLE: if (accept) begin
          op_q    <= op_i;
          idx     <= '0;
          cs_n_q  <= 1'b0;
          err_q   <= 1'b0;
          err_out <= 1'b0;
          state   <= S_RUN;
        end
        S_RUN: case (cur.kind)
          K_BYTE: state <= S_BYTE;
          K_WAIT: begin cnt <= CW'(WAIT_CYC - 1); state <= S_WAIT; end
          K_DRDY: begin cnt <= CW'(DRDY_TO_CYC - 1); state <= S_DRDY; end
          default: begin cs_n_q <= 1'b1; cnt <= CW'(CSH_CYC - 1); state <= S_CSH; end
        endcase
        S_BYTE: if (eng_done) begin
          if (cur.cap == C_REG && int'(cur.slot) < NREG)
            reg_q[int'(cur.slot)*8 +: 8] <= eng_rx;
          else if (cur.cap == C_CONV)
            conv_q <= {conv_q[15:0], eng_rx};
          idx   <= idx + 5'd1;
          state <= S_RUN;
        end
        S_WAIT: if (cnt == '0) begin
          idx   <= idx + 5'd1;
          state <= S_RUN;
        end else cnt <= cnt - CW'(1);
        S_DRDY: if (drdy_low) begin
          idx   <= idx + 5'd1;
          state <= S_RUN;
        end else if (to_expire) begin
          err_q  <= 1'b1;
          cs_n_q <= 1'b1;
          cnt    <= CW'(CSH_CYC - 1);
          state  <= S_CSH;
        end else cnt <= cnt - CW'(1);
        S_CSH: if (seq_done_ev) begin
          err_out <= err_q;
          state   <= S_IDLE;
        end else cnt <= cnt - CW'(1);
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (state != S_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_out;
  assign reg_data_o  = reg_q;
  assign conv_data_o = conv_q;
  assign cs_n_o      = cs_n_q;

  // checker-only counter of consecutive chip-select high cycles
  logic [CW-1:0] csh_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csh_seen <= CW'(CSH_CYC);
    else if (!cs_n_q) csh_seen <= '0;
    else if (csh_seen < CW'(CSH_CYC)) csh_seen <= csh_seen + CW'(1);
  end

  // R2: no clock activity outside the chip-select window
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
  // R4: every byte transfer sits inside chip-select low
  p_byte_framed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !cs_n_o);
  // R7: read-data command only after data-ready was seen low
  p_drdy_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_go |-> $past(drdy_low));
  // R8: the error flag rises together with done
  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);
  // R9: a request during a script leaves the chosen operation alone
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(op_q));
  // R10: done lasts one cycle and coincides with busy falling
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  // R10: chip-select stays high for the minimum time before a new window
  p_csh_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (csh_seen >= CW'(CSH_CYC)));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
module dev_model #(
  parameter bit LATCH_FALL = 1'b1
) (
  input  logic        cs_n,
  input  logic        sclk,
  input  logic        din,
  input  logic [23:0] conv_val,
  output logic        dout
);
  logic [7:0] regs [12];
  logic [7:0] log_q [$];
  time        first_t [$];
  time        last_t [$];
  int         lat_n, lau_n, st, k;
  logic [7:0] rxb, outb;

  initial begin
    regs[0] = 8'h31; regs[1] = 8'h01; regs[2]  = 8'h20; regs[3]  = 8'hF0;
    regs[4] = 8'hE0; regs[5] = 8'h00; regs[6]  = 8'h00; regs[7]  = 8'h5A;
    regs[8] = 8'hA5; regs[9] = 8'h3C; regs[10] = 8'hC3; regs[11] = 8'h81;
    dout = 1'b0; lat_n = 0; lau_n = 0; st = 0; k = 0; rxb = 0; outb = 0;
  end

  function automatic logic [7:0] cur_out();
    if (st == 2) return regs[k];
    if (st == 3) return 8'(conv_val >> (16 - 8 * k));
    return 8'h00;
  endfunction

  task automatic byte_done(input logic [7:0] b);
    log_q.push_back(b);
    case (st)
      0: if (b == 8'h10) st = 1; else if (b == 8'h01) begin st = 3; k = 0; end
      1: begin st = 2; k = 0; end
      2: begin k++; if (k == 12) st = 0; end
      3: begin k++; if (k == 3) st = 0; end
      default: st = 0;
    endcase
  endtask

  task automatic do_latch();
    rxb = {rxb[6:0], din};
    if (lat_n % 8 == 0) first_t.push_back($time);
    lat_n++;
    if (lat_n % 8 == 0) begin
      last_t.push_back($time);
      byte_done(rxb);
    end
  endtask

  task automatic do_launch();
    if (lau_n % 8 == 0) outb = cur_out();
    dout = outb[7 - (lau_n % 8)];
    lau_n++;
  endtask

  always @(negedge cs_n) begin
    lat_n = 0; lau_n = 0; st = 0; k = 0;
    if (!LATCH_FALL) do_launch();
  end
  always @(posedge sclk) if (!cs_n) begin
    if (LATCH_FALL) do_launch(); else do_latch();
  end
  always @(negedge sclk) if (!cs_n) begin
    if (LATCH_FALL) do_latch(); else do_launch();
  end
endmodule

module sim_adc_seq_ctrl;
  localparam int  NREG  = 12;
  localparam time TCK   = 8ns;
  localparam int  B_HALF = 125_000_000 / (2 * 1_714_000);
  localparam int  B_WAIT = (125 * 6);
  localparam int  B_CSH  = 2 * B_HALF;
  localparam int  TO_CYC = 4000;

  typedef struct {
    bit          op;
    bit          err;
    logic [23:0] conv;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op = 1'b0, drdy_n = 1'b1;
  logic [23:0] conv_val = 24'h0;
  logic busy0, done0, err0, cs0, sclk0, din0, dout0;
  logic busy1, done1, err1, cs1, sclk1, din1, dout1;
  logic [NREG*8-1:0] regs0, regs1;
  logic signed [23:0] conv0, conv1;

  int checks = 0, bad = 0, dones = 0;
  item_t sb_q [$];
  time cs_rise_t = 0, drdy_fall_t = 0;
  time sedge_q [$];
  bit  rec_edges = 1'b0;
  logic [NREG*8-1:0] regs_exp;

  always #(TCK/2) clk = ~clk;

  adc_seq_ctrl #(.SAMPLE_ON_FALL(1'b1), .DRDY_TO_CYC(TO_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .busy_o(busy0), .done_o(done0),
    .err_o(err0), .reg_data_o(regs0), .conv_data_o(conv0), .cs_n_o(cs0), .sclk_o(sclk0),
    .din_o(din0), .dout_i(dout0), .drdy_n_i(drdy_n));
  adc_seq_ctrl #(.SAMPLE_ON_FALL(1'b0), .DRDY_TO_CYC(TO_CYC)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .busy_o(busy1), .done_o(done1),
    .err_o(err1), .reg_data_o(regs1), .conv_data_o(conv1), .cs_n_o(cs1), .sclk_o(sclk1),
    .din_o(din1), .dout_i(dout1), .drdy_n_i(drdy_n));

  dev_model #(.LATCH_FALL(1'b1)) m0 (.cs_n(cs0), .sclk(sclk0), .din(din0), .conv_val(conv_val), .dout(dout0));
  dev_model #(.LATCH_FALL(1'b0)) m1 (.cs_n(cs1), .sclk(sclk1), .din(din1), .conv_val(conv_val), .dout(dout1));

  always @(posedge cs0) cs_rise_t = $time;
  always @(negedge drdy_n) drdy_fall_t = $time;
  always @(sclk0) if (rec_edges) sedge_q.push_back($time);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input bit o, input bit e, input int i);
    if (!o) begin
      if (i == 0) return 8'h0F;
      if (i == 1) return 8'h10;
      if (i == 2) return 8'(NREG - 1);
      return 8'hFF;
    end
    if (i == 0) return 8'hFC;
    if (i == 1) return 8'hFF;
    if (i == 2) return 8'h01;
    return 8'hFF;
  endfunction

  function automatic int exp_len(input bit o, input bit e);
    if (!o) return 3 + NREG;
    return e ? 2 : 6;
  endfunction

  task automatic cmp_stream(input bit o, input bit e, input logic [7:0] got [$], input string tag);
    chk(got.size() == exp_len(o, e), o ? "R5" : "R4", {tag, " byte count"}, got.size(), exp_len(o, e));
    for (int i = 0; i < got.size() && i < exp_len(o, e); i++)
      chk(got[i] == exp_byte(o, e, i), o ? "R5 R11" : "R4 R11", {tag, " command byte"}, got[i], exp_byte(o, e, i));
  endtask

  // scoreboard monitor
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (done0) begin
        dones++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 1, 0);
        end else begin
          it = sb_q.pop_front();
          chk(done1 == 1'b1, "R3", "second-mode done alignment", done1, 1);
          chk(busy0 == 1'b0, "R10", "busy low with done", busy0, 0);
          chk(($time - cs_rise_t) >= B_CSH * TCK, "R10", "cs high time before done",
              ($time - cs_rise_t) / TCK, B_CSH);
          chk(err0 == it.err, "R8", "error flag", err0, it.err);
          chk(err1 == it.err, "R8", "error flag other mode", err1, it.err);
          cmp_stream(it.op, it.err, m0.log_q, "rise-launch");
          cmp_stream(it.op, it.err, m1.log_q, "fall-launch");
          if (!it.op) begin
            chk(regs0 == regs_exp, "R4", "register bytes", regs0[63:0], regs_exp[63:0]);
            chk(regs1 == regs_exp, "R3", "register bytes other edge", regs1[63:0], regs_exp[63:0]);
          end else if (!it.err) begin
            chk(conv0 == it.conv, "R5", "conversion", conv0, it.conv);
            chk(conv1 == it.conv, "R3", "conversion other edge", conv1, it.conv);
            if (m0.first_t.size() >= 4) begin
              chk(m0.first_t[1] - m0.last_t[0] >= B_WAIT * TCK, "R6", "gap sync-wake",
                  (m0.first_t[1] - m0.last_t[0]) / TCK, B_WAIT);
              chk(m0.first_t[2] - m0.last_t[1] >= B_WAIT * TCK, "R6", "gap wake-rdata",
                  (m0.first_t[2] - m0.last_t[1]) / TCK, B_WAIT);
              chk(m0.first_t[3] - m0.last_t[2] >= B_WAIT * TCK, "R6", "gap rdata-data",
                  (m0.first_t[3] - m0.last_t[2]) / TCK, B_WAIT);
              chk(m0.first_t[2] > drdy_fall_t, "R7", "rdata after drdy low",
                  m0.first_t[2] / TCK, drdy_fall_t / TCK);
            end else chk(1'b0, "R6", "byte timing samples", m0.first_t.size(), 4);
          end else begin
            chk(cs0 == 1'b1, "R8", "cs high after timeout", cs0, 1);
          end
        end
        m0.log_q.delete(); m0.first_t.delete(); m0.last_t.delete();
        m1.log_q.delete(); m1.first_t.delete(); m1.last_t.delete();
      end
    end
  end

  // driver
  task automatic issue(input bit o, input bit e, input logic [23:0] cv);
    item_t it;
    it.op = o; it.err = e; it.conv = cv;
    sb_q.push_back(it);
    @(negedge clk); start = 1'b1; op = o;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done0);
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(TCK * 200000);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    regs_exp = {8'h81, 8'hC3, 8'h3C, 8'hA5, 8'h5A, 8'h00, 8'h00,
                8'hE0, 8'hF0, 8'h20, 8'h01, 8'h31};
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs0 == 1'b1 && cs1 == 1'b1, "R1", "cs idle", cs0, 1);
    chk(sclk0 == 1'b0 && sclk1 == 1'b0, "R1", "sclk idle", sclk0, 0);
    chk(busy0 == 1'b0 && done0 == 1'b0, "R1", "busy/done idle", {busy0, done0}, 0);
    chk(regs0 == '0 && conv0 == '0, "R1", "outputs cleared", conv0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // register dump, with a stray start while busy (R9)
    rec_edges = 1'b1;
    issue(1'b0, 1'b0, 24'h0);
    repeat (200) @(negedge clk);
    start = 1'b1; op = 1'b1;
    @(negedge clk); start = 1'b0; op = 1'b0;
    wait_done();
    rec_edges = 1'b0;
    if (sedge_q.size() >= 3) begin
      chk(sedge_q[1] - sedge_q[0] == B_HALF * TCK, "R2", "sclk high time",
          (sedge_q[1] - sedge_q[0]) / TCK, B_HALF);
      chk(sedge_q[2] - sedge_q[1] == B_HALF * TCK, "R2", "sclk low time",
          (sedge_q[2] - sedge_q[1]) / TCK, B_HALF);
    end else chk(1'b0, "R2", "sclk edge samples", sedge_q.size(), 3);

    // conversion with late data-ready, negative code
    conv_val = 24'h800001;
    drdy_n = 1'b1;
    issue(1'b1, 1'b0, 24'h800001);
    repeat (3500) @(negedge clk);
    drdy_n = 1'b0;
    wait_done();
    drdy_n = 1'b1;

    // conversion with data-ready already low, largest positive code
    conv_val = 24'h7FFFFF;
    repeat (10) @(negedge clk);
    drdy_n = 1'b0;
    issue(1'b1, 1'b0, 24'h7FFFFF);
    wait_done();
    drdy_n = 1'b1;

    // timeout: data-ready never falls (R8)
    conv_val = 24'h123456;
    issue(1'b1, 1'b1, 24'h0);
    wait_done();

    // recovery after timeout clears the error (R8)
    drdy_n = 1'b0;
    conv_val = 24'h0A5C3E;
    issue(1'b1, 1'b0, 24'h0A5C3E);
    wait_done();

    // a second dump confirms the sequence repeats
    issue(1'b0, 1'b0, 24'h0);
    wait_done();

    repeat (20) @(negedge clk);
    chk(sb_q.size() == 0, "R9", "pending scoreboard items", sb_q.size(), 0);
    chk(dones == 6, "R9", "done pulses", dones, 6);
    summary();
  end
endmodule